// File: doc/BRIEF.md
# Debug Serial Link Target Port

This block is the target end of a synchronous serial debug link. An external debug host drives a serial clock and a serial data line. Neither is related to the local processor-status clock, so both pass through synchronizer stages. A serial clock level is trusted only after it reads the same on two consecutive local clock edges. On every trusted low-to-high transition of the serial clock, the block takes in one command bit and drives the next response bit out.

Packets are 17 bits long and travel most significant bit first in both directions. When the seventeenth bit of a packet arrives, the complete command word goes to the debug module with a one-cycle valid strobe. The debug module offers its next response as a word plus a ready level. The response is taken at the first trusted rising edge of a packet. If no response is offered, the packet returns all ones, which the host reads as "not ready". The serial output always comes from a register.

Top module: `dbgSerialPort`

## Requirements
- R1: After reset, serDataOut is 0, rxValid is 0, rxWord is 0 and txTaken is 0.
- R2: A new serClkIn level takes effect only after it has been sampled equal on two consecutive clk edges after synchronization. A high pulse on serClkIn that lasts a single clk cycle shifts no bit and does not disturb packet alignment.
- R3: serDataIn is sampled at each accepted rising edge of serClkIn. The 17 bits of a packet form rxWord with the first bit at position 16 (most significant bit first).
- R4: One clk cycle after the accepted rising edge that carries the 17th bit, rxValid is high for exactly one cycle. rxWord then holds its value until the next packet completes.
- R5: At the first accepted rising edge of a packet, if txReady is high, txWord is taken. Its bit 16 appears on serDataOut at that edge, and bits 15 down to 0 follow at the next 16 accepted rising edges.
- R6: If txReady is low at the first accepted rising edge of a packet, the packet sends 17 ones (0x1FFFF) on serDataOut.
- R7: txTaken pulses high for one clk cycle for each packet whose response word was taken, and stays low for packets sent with the not-ready pattern.
- R8: serDataOut changes only at an accepted rising edge of serClkIn. It stays constant through each low phase of serClkIn.
- R9: Packets are received correctly when serClkIn runs at one fifth of the clk rate (high for 3 clk cycles, low for 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-status clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| serClkIn | input | 1 | Serial clock from the debug host, asynchronous |
| serDataIn | input | 1 | Serial command data, asynchronous |
| serDataOut | output | 1 | Registered serial response data |
| rxWord | output | 17 | Last complete command word received |
| rxValid | output | 1 | One-cycle strobe when rxWord is updated |
| txWord | input | 17 | Response word offered by the debug module |
| txReady | input | 1 | High when txWord holds a response to send |
| txTaken | output | 1 | One-cycle strobe when txWord has been loaded |

## Verification
A bit counter that is off by one, or an edge validator that lets a glitch through, moves every later bit. The error shows at the port as an rxValid pulse early or late, and as a rotated rxWord no later than the end of the packet in progress. If the transmit register fails to load at the packet boundary, or loads in the wrong place, serDataOut shows a wrong bit within the same packet. A missing not-ready substitution shows as a non-ones packet. A serial output that moves during a low phase is caught on the next sample taken before the following rising edge.

// File: rtl/dbgSerPkg.sv
package dbgSerPkg;
  // Strobes from the control to the datapath, all valid in one clk cycle.
  typedef struct packed {
    logic shiftEn;  // accepted rising edge of the serial clock
    logic loadTx;   // first bit of a packet: load the transmit register
    logic takeTx;   // loadTx with a response offered
    logic lastBit;  // final bit of a packet is being shifted in
  } ctlStrobes_t;
endpackage

// File: rtl/dbgSerSync.sv
module dbgSerSync #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClkIn,
  input  logic serDataIn,
  output logic riseDet,
  output logic dataBit
);
  localparam int DATA_DEPTH = SYNC_DEPTH + 1;

  logic [SYNC_DEPTH-1:0] clkChain;
  logic [DATA_DEPTH-1:0] dataChain;
  logic holdLvl;
  logic vClk;
  logic clkS;

  // Synchronizer stages for the serial clock.
  for (genvar i = 0; i < SYNC_DEPTH; i++) begin : g_clkSync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) clkChain[i] <= 1'b0;
        else       clkChain[i] <= serClkIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) clkChain[i] <= 1'b0;
        else       clkChain[i] <= clkChain[i-1];
      end
    end
  end

  // The data chain is one stage longer so that it lines up with the validated clock.
  for (genvar i = 0; i < DATA_DEPTH; i++) begin : g_dataSync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) dataChain[i] <= 1'b0;
        else       dataChain[i] <= serDataIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) dataChain[i] <= 1'b0;
        else       dataChain[i] <= dataChain[i-1];
      end
    end
  end

  assign clkS = clkChain[SYNC_DEPTH-1];

  // The level becomes valid once two consecutive samples agree.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdLvl <= 1'b0;
      vClk    <= 1'b0;
    end else begin
      holdLvl <= clkS;
      if (clkS == holdLvl) vClk <= clkS;
    end
  end

  assign riseDet = (clkS == holdLvl) && clkS && !vClk;
  assign dataBit = dataChain[DATA_DEPTH-1];

  // R2: the validated level only moves after two equal samples
  a_r2_two_equal_samples: assert property (@(posedge clk) disable iff (!rstN)
    (vClk != $past(vClk)) |-> ($past(clkS) == $past(holdLvl)));

  // R8: an accepted rising edge is never reported on two cycles in a row
  a_r8_single_rise: assert property (@(posedge clk) disable iff (!rstN)
    riseDet |=> !riseDet);
endmodule

// File: rtl/dbgSerCtrl.sv
module dbgSerCtrl
  import dbgSerPkg::*;
#(
  parameter int WORD_W = 17
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        riseDet,
  input  logic        txReady,
  output ctlStrobes_t ctl,
  output logic        txTaken
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    ctl.shiftEn = riseDet;
    ctl.loadTx  = riseDet && (bitCnt == '0);
    ctl.takeTx  = riseDet && (bitCnt == '0) && txReady;
    ctl.lastBit = riseDet && (bitCnt == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      txTaken <= 1'b0;
    end else begin
      txTaken <= ctl.takeTx;
      if (riseDet) begin
        if (bitCnt == LAST_IDX) bitCnt <= '0;
        else                    bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R4: the bit counter never passes the last bit of a packet
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_IDX);

  // R7: a take strobe follows a packet start with a response offered
  a_r7_taken_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    txTaken |-> ($past(txReady) && $past(riseDet)));

  // R7: the take strobe is one cycle long
  a_r7_taken_pulse: assert property (@(posedge clk) disable iff (!rstN)
    txTaken |=> !txTaken);
endmodule

// File: rtl/dbgSerDatapath.sv
module dbgSerDatapath
  import dbgSerPkg::*;
#(
  parameter int WORD_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              dataBit,
  input  logic [WORD_W-1:0] txWord,
  output logic              serDataOut,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid
);
  logic [WORD_W-2:0] rxShift;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] txSrc;

  assign txSrc = ctl.takeTx ? txWord : '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift    <= '0;
      txShift    <= '0;
      serDataOut <= 1'b0;
      rxWord     <= '0;
      rxValid    <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (ctl.shiftEn) begin
        rxShift <= {rxShift[WORD_W-3:0], dataBit};
        if (ctl.loadTx) begin
          serDataOut <= txSrc[WORD_W-1];
          txShift    <= {txSrc[WORD_W-2:0], 1'b0};
        end else begin
          serDataOut <= txShift[WORD_W-1];
          txShift    <= {txShift[WORD_W-2:0], 1'b0};
        end
        if (ctl.lastBit) begin
          rxWord  <= {rxShift, dataBit};
          rxValid <= 1'b1;
        end
      end
    end
  end

  // R8: the serial output only moves on an accepted rising edge
  a_r8_dso_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.shiftEn |=> $stable(serDataOut));

  // R4: the valid strobe is a single cycle
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R6: a packet start with nothing offered drives a one
  a_r6_not_ready_one: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadTx && !ctl.takeTx) |=> serDataOut);

  // R4: the received word only changes together with the strobe
  a_r4_word_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxWord));
endmodule

// File: rtl/dbgSerialPort.sv
module dbgSerialPort
  import dbgSerPkg::*;
#(
  parameter int WORD_W     = 17,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClkIn,
  input  logic              serDataIn,
  output logic              serDataOut,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txReady,
  output logic              txTaken
);
  ctlStrobes_t ctl;
  logic riseDet;
  logic dataBit;

  dbgSerSync #(.SYNC_DEPTH(SYNC_DEPTH)) sync_i (
    .clk(clk), .rstN(rstN), .serClkIn(serClkIn), .serDataIn(serDataIn),
    .riseDet(riseDet), .dataBit(dataBit)
  );

  dbgSerCtrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .riseDet(riseDet), .txReady(txReady),
    .ctl(ctl), .txTaken(txTaken)
  );

  dbgSerDatapath #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataBit(dataBit), .txWord(txWord),
    .serDataOut(serDataOut), .rxWord(rxWord), .rxValid(rxValid)
  );
endmodule

// File: tb/dbgSerialPort_tb_top.sv
module dbgSerialPort_tb_top;
  localparam int W = 17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClkIn = 1'b0;
  logic serDataIn = 1'b0;
  logic serDataOut;
  logic [W-1:0] rxWord;
  logic rxValid;
  logic [W-1:0] txWord = '0;
  logic txReady = 1'b0;
  logic txTaken;

  int checks = 0;
  int errors = 0;
  int rxCount = 0;
  int takenCount = 0;
  int validRun = 0;
  int maxValidRun = 0;
  logic [W-1:0] lastRx = '0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  dbgSerialPort dut_i (
    .clk(clk), .rstN(rstN), .serClkIn(serClkIn), .serDataIn(serDataIn),
    .serDataOut(serDataOut), .rxWord(rxWord), .rxValid(rxValid),
    .txWord(txWord), .txReady(txReady), .txTaken(txTaken)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      rxCount++;
      lastRx = rxWord;
      validRun++;
      if (validRun > maxValidRun) maxValidRun = validRun;
    end else validRun = 0;
    if (txTaken) takenCount++;
  end

  function automatic logic [W-1:0] expResp(bit ready, logic [W-1:0] w);
    return ready ? w : {W{1'b1}};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One serial bit: rising edge with data, hold high, then low phase.
  // Returns the serial output seen at the end of the high phase, and flags a change during the low phase.
  task automatic sendBit(bit b, int hi, int lo, bit glitch, output bit dso, output bit lowMoved);
    @(negedge clk);
    serDataIn = b;
    serClkIn = 1'b1;
    repeat (hi - 1) @(negedge clk);
    dso = serDataOut;
    @(negedge clk);
    serClkIn = 1'b0;
    if (glitch) begin
      repeat (2) @(negedge clk);
      serClkIn = 1'b1;
      @(negedge clk);
      serClkIn = 1'b0;
      repeat (lo - 4) @(negedge clk);
    end else begin
      repeat (lo - 1) @(negedge clk);
    end
    lowMoved = (serDataOut != dso);
  endtask

  task automatic sendPacket(logic [W-1:0] cmd, bit ready, logic [W-1:0] resp,
                            int hi, int lo, bit glitch, bit checkDso);
    logic [W-1:0] got = '0;
    bit moved = 0;
    int rx0 = rxCount;
    int tk0 = takenCount;
    txWord = resp;
    txReady = ready;
    for (int i = W - 1; i >= 0; i--) begin
      bit d;
      bit m;
      sendBit(cmd[i], hi, lo, glitch && (i % 5 == 2), d, m);
      got[i] = d;
      moved = moved | m;
      if (i == W - 1) txReady = 1'b0;
      if (i == 1) check(rxCount == rx0, "R4 no early strobe", rxCount, rx0);
    end
    repeat (8) @(negedge clk);
    check(rxCount == rx0 + 1, glitch ? "R2 glitch ignored count" : "R4 one strobe per packet",
          rxCount, rx0 + 1);
    check(lastRx == cmd, glitch ? "R2 glitch ignored word" : (hi == 3 ? "R9 fast rate word" : "R3 received word"),
          lastRx, cmd);
    check(takenCount == tk0 + (ready ? 1 : 0), "R7 take strobe count", takenCount, tk0 + (ready ? 1 : 0));
    if (checkDso) begin
      check(got == expResp(ready, resp), ready ? "R5 response bits" : "R6 not ready pattern",
            got, expResp(ready, resp));
      check(!moved, "R8 output steady while clock low", moved, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (5) @(negedge clk);
    check(serDataOut == 1'b0, "R1 output low", serDataOut, 0);
    check(rxValid == 1'b0, "R1 valid low", rxValid, 0);
    check(rxWord == '0, "R1 word zero", rxWord, 0);
    check(txTaken == 1'b0, "R1 taken low", txTaken, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // Directed corner cases.
    sendPacket(17'h1A5C3, 1'b1, 17'h0F0F1, 6, 6, 1'b0, 1'b1);
    sendPacket(17'h00000, 1'b0, 17'h12345, 6, 6, 1'b0, 1'b1);
    sendPacket(17'h1FFFF, 1'b1, 17'h00000, 6, 6, 1'b0, 1'b1);
    sendPacket(17'h10001, 1'b1, 17'h15555, 6, 8, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    check(rxWord == 17'h10001, "R4 word held", rxWord, 17'h10001);
    sendPacket(17'h0AAAA, 1'b0, 17'h00001, 3, 2, 1'b0, 1'b0);

    // Random traffic.
    for (int n = 0; n < 24; n++) begin
      logic [W-1:0] c;
      logic [W-1:0] r;
      bit rd;
      bit fast;
      c = W'($urandom);
      r = W'($urandom);
      rd = 1'($urandom);
      fast = ($urandom % 4) == 0;
      if (fast) sendPacket(c, rd, r, 3, 2, 1'b0, 1'b0);
      else      sendPacket(c, rd, r, 5 + int'($urandom % 3), 5 + int'($urandom % 3), 1'b0, 1'b1);
    end

    check(maxValidRun == 1, "R4 strobe length", maxValidRun, 1);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule